// File: doc/BRIEF.md
# Breaker Failure Detection Logic

This block decides, one clock tick at a time, whether a circuit breaker has failed to clear fault current after a trip was initiated. It takes three per-phase overcurrent flags and a three-pole initiate. It also takes three per-phase initiates and two programmable pickup counts, given in clock ticks. From these it raises a failure flag and a retrip flag for each phase, a pair of flags for the three-pole path, and two summary outputs.

Four identical source paths feed the summary outputs: one for each phase, and one for the three-pole initiate. In the three-pole path the overcurrent flags of all three phases are ORed. Each path holds a failure pickup timer and a separate retrip pickup timer.

A mode input, captured only while reset is held, selects the behaviour:
- **Current-gated mode (mode 0):** the current check is ANDed into the inputs of both timers.
- **Multiphase mode (mode 1):** the timers run on the initiate alone. A failure is declared only when current is still present at expiry and at least two phases are initiated.

Each timer is a small state machine with three states: `TMR_IDLE` (count zero), `TMR_RUN` (counting) and `TMR_DONE` (count saturated). Its transitions are:
- start: `TMR_IDLE` to `TMR_RUN`, when the input is high.
- saturate: `TMR_RUN` to `TMR_DONE`, when the count reaches its maximum.
- hold: `TMR_DONE` stays in `TMR_DONE` while the input stays high.
- clear: any state to `TMR_IDLE`, when the input is low.

A timer reports "reached" while its input is high and its count is at least the pickup value. The reached flag feeds the registered outputs.

Top module: `bkr_fail_detect`

## Requirements
- R1: A synchronous active-high reset clears every output and timer. The mode input (0 = current-gated, 1 = multiphase) is captured only on edges where reset is high; changing it later has no effect.
- R2: Call a timer's input its qualifying input. The failure output goes high after the edge that samples that input high for the (P+1)-th consecutive time, where P is the failure pickup. A pickup of 0 gives assertion after the first such edge. Before that edge the output stays low.
- R3: In current-gated mode, the qualifying input of phase i is `init_ph[i] AND oc[i]`. For the three-pole path it is `init_3p AND (oc[0] OR oc[1] OR oc[2])`. Without current, neither timer of a path runs.
- R4: Each path has a separate retrip timer with its own pickup Q. It follows the R2 timing with Q in place of P and drives `retrip_ph[i]`, or the three-pole retrip flag.
- R5: In multiphase mode, the timers of a path are qualified by its initiate alone. A path's failure output is high only if three things hold at the edge where its timer has reached P:
  - its overcurrent flag is high (for the three-pole path, any phase's flag);
  - at least two of the three bits `init_ph[i] OR init_3p` are high;
  - its initiate is high.
- R6: If the overcurrent flag clears at or before the expiry edge, the failure output does not assert. In current-gated mode the timer also restarts from zero.
- R7: Dropout delay is zero. An edge that samples a path's qualifying condition false leaves that path's outputs low after that edge.
- R8: `fail_any` is high exactly when any `fail_ph` bit or the three-pole failure flag is high. `retrip_any` is formed the same way from the retrip flags. The three-pole path never sets a `fail_ph` or `retrip_ph` bit.
- R9: In multiphase mode the retrip outputs depend on neither current nor the two-of-three vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Mode, sampled during reset: 0 current-gated, 1 multiphase |
| oc | input | 3 | Per-phase overcurrent flags, bit 0 = A, bit 1 = B, bit 2 = C |
| init_3p | input | 1 | Three-pole failure initiate |
| init_ph | input | 3 | Per-phase failure initiates, same bit order as `oc` |
| fail_pick | input | CW | Failure pickup count in ticks |
| retrip_pick | input | CW | Retrip pickup count in ticks |
| fail_any | output | 1 | Overall failure flag |
| fail_ph | output | 3 | Per-phase failure flags |
| retrip_any | output | 1 | Overall retrip flag |
| retrip_ph | output | 3 | Per-phase retrip flags |

## Verification
A timer stuck in the wrong state, or holding a wrong count, shows at the ports as a failure or retrip flag that rises one or more edges early or late compared with the P+1 and Q+1 edge counts. It can also show as a flag that rises again without a fresh run after a current dropout. A wrong captured mode shows within P+1 edges: a single-phase fault either fails when it should not, or stays silent when it should fail. The sweeps therefore check every edge of every run, not only the final state, so an off-by-one in the count appears at the first edge where it differs.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    typedef enum logic {
        BFD_MODE_GATED = 1'b0,
        BFD_MODE_MULTI = 1'b1
    } bfd_mode_e;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_DONE = 2'd2
    } tmr_state_e;

    localparam int unsigned BFD_PHASES = 3;
    localparam int unsigned BFD_PATHS  = BFD_PHASES + 1;

    // True when at least two of the three bits are set.
    function automatic logic vote_two(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/bfd_pickup_timer.sv
module bfd_pickup_timer
    import bfd_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] pick,
    output logic          reach
);

    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (run) begin
                    cnt_d   = CNT_ONE;
                    state_d = (CNT_ONE == CNT_MAX) ? TMR_DONE : TMR_RUN;
                end
            end
            TMR_RUN: begin
                if (!run) begin
                    cnt_d   = '0;
                    state_d = TMR_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                    if (cnt_d == CNT_MAX) begin
                        state_d = TMR_DONE;
                    end
                end
            end
            TMR_DONE: begin
                if (!run) begin
                    cnt_d   = '0;
                    state_d = TMR_IDLE;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = TMR_IDLE;
            end
        endcase
    end

    // Output: reached while the input is live and enough ticks have elapsed
    always_comb begin
        reach = run && (cnt_q >= pick);
    end

endmodule

// File: rtl/bfd_source_path.sv
module bfd_source_path
    import bfd_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bfd_mode_e     mode,
    input  logic          init,
    input  logic          cur,
    input  logic          vote_ok,
    input  logic [CW-1:0] fail_pick,
    input  logic [CW-1:0] retrip_pick,
    output logic          fail_q,
    output logic          retrip_q
);

    logic run_q_in;
    logic fail_reach;
    logic rt_reach;
    logic fail_gate;
    logic fail_d;
    logic rt_d;

    // Timer qualification per mode
    always_comb begin
        unique case (mode)
            BFD_MODE_GATED: begin
                run_q_in  = init & cur;
                fail_gate = 1'b1;
            end
            BFD_MODE_MULTI: begin
                run_q_in  = init;
                fail_gate = cur & vote_ok;
            end
            default: begin
                run_q_in  = 1'b0;
                fail_gate = 1'b0;
            end
        endcase
    end

    bfd_pickup_timer #(.CW(CW)) u_fail_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q_in),
        .pick  (fail_pick),
        .reach (fail_reach)
    );

    bfd_pickup_timer #(.CW(CW)) u_rt_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q_in),
        .pick  (retrip_pick),
        .reach (rt_reach)
    );

    always_comb begin
        fail_d = fail_reach & fail_gate;
        rt_d   = rt_reach;
    end

    // Output register, zero dropout
    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q   <= 1'b0;
            retrip_q <= 1'b0;
        end else begin
            fail_q   <= fail_d;
            retrip_q <= rt_d;
        end
    end

endmodule

// File: rtl/bkr_fail_detect.sv
module bkr_fail_detect
    import bfd_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_sel,
    input  logic [2:0]    oc,
    input  logic          init_3p,
    input  logic [2:0]    init_ph,
    input  logic [CW-1:0] fail_pick,
    input  logic [CW-1:0] retrip_pick,
    output logic          fail_any,
    output logic [2:0]    fail_ph,
    output logic          retrip_any,
    output logic [2:0]    retrip_ph
);

    localparam int unsigned TP_IDX = BFD_PATHS - 1;

    bfd_mode_e             mode_q;
    logic                  vote_ok;
    logic [BFD_PATHS-1:0]  path_init;
    logic [BFD_PATHS-1:0]  path_cur;
    logic [BFD_PATHS-1:0]  path_fail;
    logic [BFD_PATHS-1:0]  path_rt;

    // Mode captured only while reset is asserted
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= bfd_mode_e'(mode_sel);
        end
    end

    always_comb begin
        vote_ok = vote_two(init_ph | {BFD_PHASES{init_3p}});
        path_init = {init_3p, init_ph};
        path_cur  = {|oc, oc};
    end

    for (genvar g = 0; g < BFD_PATHS; g++) begin : g_path
        bfd_source_path #(.CW(CW)) u_path (
            .clk         (clk),
            .rst         (rst),
            .mode        (mode_q),
            .init        (path_init[g]),
            .cur         (path_cur[g]),
            .vote_ok     (vote_ok),
            .fail_pick   (fail_pick),
            .retrip_pick (retrip_pick),
            .fail_q      (path_fail[g]),
            .retrip_q    (path_rt[g])
        );
    end

    always_comb begin
        fail_ph    = path_fail[BFD_PHASES-1:0];
        retrip_ph  = path_rt[BFD_PHASES-1:0];
        fail_any   = (|path_fail[BFD_PHASES-1:0]) | path_fail[TP_IDX];
        retrip_any = (|path_rt[BFD_PHASES-1:0]) | path_rt[TP_IDX];
    end

endmodule

// File: rtl/bfd_checker.sv
module bfd_checker
    import bfd_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst,
    input bfd_mode_e     mode_q,
    input logic [2:0]    oc,
    input logic          init_3p,
    input logic [2:0]    init_ph,
    input logic [CW-1:0] fail_pick,
    input logic          fail_any,
    input logic [2:0]    fail_ph,
    input logic          retrip_any,
    input logic [2:0]    retrip_ph
);

    // R1: reset leaves all outputs low
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!fail_any && !retrip_any && fail_ph == 3'b000 && retrip_ph == 3'b000));

    for (genvar i = 0; i < 3; i++) begin : g_ph
        // R7: no initiate means outputs low after the edge
        a_r7_zero_dropout: assert property (@(posedge clk) disable iff (rst)
            !init_ph[i] |=> (!fail_ph[i] && !retrip_ph[i]));

        // R6: no current means no failure after the edge
        a_r6_no_current_no_fail: assert property (@(posedge clk) disable iff (rst)
            !oc[i] |=> !fail_ph[i]);

        // R5: in multiphase mode a failed vote blocks failure
        a_r5_vote_required: assert property (@(posedge clk) disable iff (rst)
            (mode_q == BFD_MODE_MULTI && !vote_two(init_ph | {3{init_3p}})) |=> !fail_ph[i]);

        // R2: pickup of zero asserts on the first qualified edge
        a_r2_zero_pickup: assert property (@(posedge clk) disable iff (rst)
            (mode_q == BFD_MODE_GATED && fail_pick == '0 && init_ph[i] && oc[i]) |=> fail_ph[i]);
    end

endmodule

bind bkr_fail_detect bfd_checker #(.CW(CW)) u_bfd_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_q     (mode_q),
    .oc         (oc),
    .init_3p    (init_3p),
    .init_ph    (init_ph),
    .fail_pick  (fail_pick),
    .fail_any   (fail_any),
    .fail_ph    (fail_ph),
    .retrip_any (retrip_any),
    .retrip_ph  (retrip_ph)
);

// File: tb/bkr_fail_detect_tb_top.sv
module bkr_fail_detect_tb_top;

    localparam int unsigned CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_sel = 1'b0;
    logic [2:0]    oc = 3'b000;
    logic          init_3p = 1'b0;
    logic [2:0]    init_ph = 3'b000;
    logic [CW-1:0] fail_pick = '0;
    logic [CW-1:0] retrip_pick = '0;
    logic          fail_any;
    logic [2:0]    fail_ph;
    logic          retrip_any;
    logic [2:0]    retrip_ph;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bkr_fail_detect #(.CW(CW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .oc          (oc),
        .init_3p     (init_3p),
        .init_ph     (init_ph),
        .fail_pick   (fail_pick),
        .retrip_pick (retrip_pick),
        .fail_any    (fail_any),
        .fail_ph     (fail_ph),
        .retrip_any  (retrip_any),
        .retrip_ph   (retrip_ph)
    );

    task automatic chk(input int got, input int exp, input string req, input string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // one rising edge, then settle at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        oc = 3'b000;
        init_3p = 1'b0;
        init_ph = 3'b000;
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1;
        mode_sel = m;
        clear_inputs();
        tick();
        tick();
        rst = 1'b0;
        chk(fail_any, 0, "R1", "fail_any after reset");
        chk(retrip_any, 0, "R1", "retrip_any after reset");
        chk(fail_ph, 0, "R1", "fail_ph after reset");
        chk(retrip_ph, 0, "R1", "retrip_ph after reset");
    endtask

    // Current-gated sweep of one phase, checked on every edge
    task automatic gated_phase(input int ph, input int p, input int q);
        int len;
        len = ((p > q) ? p : q) + 3;
        fail_pick = CW'(p);
        retrip_pick = CW'(q);
        init_ph[ph] = 1'b1;
        oc[ph] = 1'b1;
        for (int k = 1; k <= len; k++) begin
            tick();
            chk(fail_ph[ph], (k >= p + 1) ? 1 : 0, "R2", "gated fail_ph edge count");
            chk(retrip_ph[ph], (k >= q + 1) ? 1 : 0, "R4", "gated retrip_ph edge count");
            chk(fail_any, (k >= p + 1) ? 1 : 0, "R8", "fail_any follows phase");
            chk(retrip_any, (k >= q + 1) ? 1 : 0, "R8", "retrip_any follows phase");
        end
        init_ph[ph] = 1'b0;
        tick();
        chk(fail_ph, 0, "R7", "fail_ph after initiate drop");
        chk(retrip_ph, 0, "R7", "retrip_ph after initiate drop");
        chk(fail_any, 0, "R7", "fail_any after initiate drop");
        clear_inputs();
        tick();
    endtask

    initial begin
        do_reset(1'b0);

        // R2/R4/R8/R7: gated sweep of pickups and phases
        for (int ph = 0; ph < 3; ph++) begin
            for (int p = 0; p < 7; p++) begin
                gated_phase(ph, p, (p + 2) % 7);
            end
        end

        // R3: initiate without current runs no timer
        fail_pick = CW'(0);
        retrip_pick = CW'(0);
        init_ph = 3'b111;
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk(fail_any, 0, "R3", "gated no current fail");
            chk(retrip_any, 0, "R3", "gated no current retrip");
        end
        clear_inputs();
        tick();

        // R6: gated, current drops on the expiry edge, then restart from zero
        for (int p = 1; p < 5; p++) begin
            fail_pick = CW'(p);
            retrip_pick = CW'(15);
            init_ph = 3'b010;
            oc = 3'b010;
            for (int k = 1; k <= p; k++) begin
                tick();
                chk(fail_ph[1], 0, "R6", "gated before expiry");
            end
            oc = 3'b000;
            tick();
            chk(fail_ph[1], 0, "R6", "gated current dropped at expiry");
            oc = 3'b010;
            for (int k = 1; k <= p + 2; k++) begin
                tick();
                chk(fail_ph[1], (k >= p + 1) ? 1 : 0, "R6", "gated restart from zero");
            end
            clear_inputs();
            tick();
        end

        // R3/R8: three-pole path in gated mode, one phase carries current
        fail_pick = CW'(3);
        retrip_pick = CW'(1);
        init_3p = 1'b1;
        oc = 3'b100;
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk(fail_any, (k >= 4) ? 1 : 0, "R3", "three-pole fail_any");
            chk(retrip_any, (k >= 2) ? 1 : 0, "R4", "three-pole retrip_any");
            chk(fail_ph, 0, "R8", "three-pole leaves fail_ph low");
            chk(retrip_ph, 0, "R8", "three-pole leaves retrip_ph low");
        end
        init_3p = 1'b0;
        tick();
        chk(fail_any, 0, "R7", "three-pole drop");
        clear_inputs();
        tick();

        // R1: mode change outside reset has no effect (stays gated)
        mode_sel = 1'b1;
        fail_pick = CW'(2);
        retrip_pick = CW'(2);
        init_ph = 3'b001;
        oc = 3'b001;
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk(fail_ph[0], (k >= 3) ? 1 : 0, "R1", "mode ignored outside reset");
        end
        clear_inputs();
        tick();

        // Switch to multiphase mode
        do_reset(1'b1);

        // R5/R9: single-phase initiate never fails, retrip still runs
        fail_pick = CW'(1);
        retrip_pick = CW'(2);
        init_ph = 3'b001;
        oc = 3'b001;
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk(fail_any, 0, "R5", "multi single phase no fail");
            chk(retrip_ph[0], (k >= 3) ? 1 : 0, "R9", "multi single phase retrip");
        end
        clear_inputs();
        tick();

        // R5: two-phase initiate with persistent current, sweep pickup
        for (int p = 0; p < 6; p++) begin
            fail_pick = CW'(p);
            retrip_pick = CW'(15);
            init_ph = 3'b011;
            oc = 3'b011;
            for (int k = 1; k <= p + 3; k++) begin
                tick();
                chk(fail_ph[0], (k >= p + 1) ? 1 : 0, "R5", "multi phase A at pickup");
                chk(fail_ph[1], (k >= p + 1) ? 1 : 0, "R5", "multi phase B at pickup");
                chk(fail_ph[2], 0, "R5", "multi phase C not initiated");
            end
            init_ph = 3'b000;
            tick();
            chk(fail_ph, 0, "R7", "multi initiate drop");
            clear_inputs();
            tick();
        end

        // R6: multi, phase A current drops on the expiry edge
        for (int p = 1; p < 5; p++) begin
            fail_pick = CW'(p);
            retrip_pick = CW'(15);
            init_ph = 3'b011;
            oc = 3'b011;
            for (int k = 1; k <= p; k++) begin
                tick();
                chk(fail_ph, 0, "R6", "multi before expiry");
            end
            oc = 3'b010;
            for (int k = 1; k <= 3; k++) begin
                tick();
                chk(fail_ph[0], 0, "R6", "multi phase A current gone");
                chk(fail_ph[1], 1, "R5", "multi phase B still fails");
            end
            clear_inputs();
            tick();
        end

        // R9/R5: initiate without current; retrip runs, failure waits for current
        fail_pick = CW'(2);
        retrip_pick = CW'(1);
        init_ph = 3'b011;
        for (int k = 1; k <= 5; k++) begin
            tick();
            chk(retrip_ph[0], (k >= 2) ? 1 : 0, "R9", "multi retrip without current");
            chk(fail_any, 0, "R5", "multi no current no fail");
        end
        oc = 3'b011;
        tick();
        chk(fail_ph, 3'b011, "R5", "multi current after expiry fails next edge");
        clear_inputs();
        tick();
        chk(fail_any, 0, "R7", "multi all clear");
        chk(retrip_any, 0, "R7", "multi retrip clear");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule